// File: doc/BRIEF.md
# Pipelined Data-Tenure Scheduler with Write Bypass

This block sits on the bus-master side of a split address/data bus. Address pipelining can leave up to two data tenures waiting after their address phases have finished. The scheduler keeps those waiting tenures in age order, each marked as a read or a write and carrying a small tag. When the data-bus arbiter sends a qualified grant pulse, the scheduler picks one waiting tenure and takes mastership for it. It then holds that tenure as the active one until a completion pulse arrives.

By default the scheduler keeps strict address order: the oldest waiting tenure runs first. A write-priority sideband input can change this. If it is high in the same cycle as an accepted grant and a write is waiting, the oldest waiting write runs ahead of any older read. The read that is passed keeps its place at the head of the remaining queue. If write-priority is high but no write is waiting, the oldest read runs as usual. Beat transfers, parity and address arbitration are handled elsewhere.

Top module: `dts_sched`

## Requirements
- R1: While reset is asserted and right after it is released, q_count is 0, and act_valid, take_mstr and ovf_err are all 0.
- R2: An accepted grant with wr_prio low makes the oldest queued entry (slot 0, the earliest enqueued) the active tenure.
- R3: An accepted grant with wr_prio high, while at least one queued entry is a write (enq_write=1 at enqueue time), makes the oldest queued write the active tenure, even when an older read is queued ahead of it.
- R4: An accepted grant with wr_prio high and only reads queued still takes mastership, and the active tenure is the oldest read.
- R5: A grant is accepted only when q_count is non-zero and no tenure is active. In any other case the grant is ignored: there is no strobe, and the queue and active state are unchanged.
- R6: After the clock edge that samples an accepted grant, take_mstr is high for exactly one cycle. In that same cycle act_valid is 1, act_write and act_tag show the chosen entry, and q_count has dropped by one.
- R7: Taking an entry out of the middle of the queue keeps the relative age order of the entries that remain. An entry enqueued later goes behind them.
- R8: An enqueue that finds the queue holding DEPTH entries, in a cycle with no accepted grant, is dropped. ovf_err is then 1 for one cycle and q_count stays at DEPTH.
- R9: A done pulse clears act_valid. A done pulse with no active tenure has no effect. An enqueue in the same cycle as done is stored.
- R10: When the queue is full and a grant is accepted in the same cycle as an enqueue, the enqueue is accepted without overflow and goes to the tail.
- R11: wr_prio has no effect in a cycle without a grant.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enq_valid | input | 1 | Enqueue a pending data tenure |
| enq_write | input | 1 | Kind of the enqueued tenure: 1 = write, 0 = read |
| enq_tag | input | TAG_W | Tag of the enqueued tenure |
| gnt | input | 1 | Qualified data-bus grant pulse |
| wr_prio | input | 1 | Write-priority sideband, sampled with gnt |
| done | input | 1 | Active tenure has completed |
| take_mstr | output | 1 | One-cycle strobe: mastership taken |
| act_valid | output | 1 | A tenure is active |
| act_write | output | 1 | Active tenure is a write |
| act_tag | output | TAG_W | Tag of the active tenure |
| q_count | output | CNT_W | Number of queued tenures |
| ovf_err | output | 1 | One-cycle pulse: an enqueue was dropped |

## Verification
The bench steps through every queue filling of length zero to two, over every read/write mix and both wr_prio levels. This separates strict-order selection, write bypass over an older read, and the fallback to a read when no write is waiting. After each bypass it enqueues a newer entry and drains the queue, to show that the passed read keeps its place ahead of it. Directed cases cover the simultaneous situations: enqueue on a full queue with and without a grant, done together with enqueue, and wr_prio without a grant. A long run of pseudo-random inputs is then compared cycle by cycle against a behavioural queue model.

// File: rtl/dts_pkg.sv
package dts_pkg;
  typedef enum logic {
    TK_READ  = 1'b0,
    TK_WRITE = 1'b1
  } tkind_e;
endpackage

// File: rtl/dts_pick.sv
// Selection of the tenure to launch: slot 0 by default, oldest write on priority.
module dts_pick #(
  parameter int DEPTH = 2,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic [DEPTH-1:0] slot_vld,
  input  logic [DEPTH-1:0] slot_wr,
  input  logic             prio,
  output logic [IDX_W-1:0] sel_idx,
  output logic             any_wr
);
  logic [DEPTH:0]   wr_seen;
  logic [DEPTH-1:0] first_wr;

  assign wr_seen[0] = 1'b0;
  for (genvar i = 0; i < DEPTH; i++) begin : g_scan
    assign first_wr[i]   = slot_vld[i] & slot_wr[i] & ~wr_seen[i];
    assign wr_seen[i+1]  = wr_seen[i] | (slot_vld[i] & slot_wr[i]);
  end
  assign any_wr = wr_seen[DEPTH];

  always_comb begin
    sel_idx = '0;
    if (prio && any_wr) begin
      for (int k = 0; k < DEPTH; k++) begin
        if (first_wr[k]) sel_idx = IDX_W'(k);
      end
    end
  end
endmodule

// File: rtl/dts_queue.sv
// Age-ordered pending storage: compacting removal at any index, append at tail.
module dts_queue #(
  parameter int DEPTH = 2,
  parameter int TAG_W = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pop,
  input  logic [IDX_W-1:0]            pop_idx,
  input  logic                        push,
  input  logic                        push_wr,
  input  logic [TAG_W-1:0]            push_tag,
  output logic [DEPTH-1:0]            slot_vld,
  output logic [DEPTH-1:0]            slot_wr,
  output logic [DEPTH-1:0][TAG_W-1:0] slot_tag,
  output logic [CNT_W-1:0]            count
);
  logic [CNT_W-1:0]            cnt_q, cnt_mid, cnt_d;
  logic [DEPTH-1:0]            wr_q, wr_d;
  logic [DEPTH-1:0][TAG_W-1:0] tag_q, tag_d;
  logic                        upd_en;

  assign cnt_mid = cnt_q - CNT_W'(pop);
  assign cnt_d   = cnt_mid + CNT_W'(push);
  assign upd_en  = pop | push;

  for (genvar i = 0; i < DEPTH; i++) begin : g_slot
    logic shift_in;
    assign shift_in = pop && (IDX_W'(i) >= pop_idx);
    always_comb begin
      wr_d[i]  = wr_q[i];
      tag_d[i] = tag_q[i];
      if (push && (CNT_W'(i) == cnt_mid)) begin
        wr_d[i]  = push_wr;
        tag_d[i] = push_tag;
      end else if (shift_in) begin
        if (i < DEPTH - 1) begin
          wr_d[i]  = wr_q[(i < DEPTH - 1) ? i + 1 : i];
          tag_d[i] = tag_q[(i < DEPTH - 1) ? i + 1 : i];
        end
      end
    end
    assign slot_vld[i] = (CNT_W'(i) < cnt_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      wr_q  <= '0;
      tag_q <= '0;
    end else if (upd_en) begin
      cnt_q <= cnt_d;
      wr_q  <= wr_d;
      tag_q <= tag_d;
    end
  end

  assign slot_wr  = wr_q;
  assign slot_tag = tag_q;
  assign count    = cnt_q;

  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(DEPTH)); // R8
  AST_POP_NONEMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> (cnt_q != '0)); // R5
endmodule

// File: rtl/dts_active.sv
// Active tenure register and mastership strobe.
module dts_active #(
  parameter int TAG_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             load_wr,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             done,
  output logic             act_valid,
  output logic             act_write,
  output logic [TAG_W-1:0] act_tag,
  output logic             take_mstr
);
  import dts_pkg::*;
  logic             vld_q, vld_d;
  tkind_e           kind_q, kind_d;
  logic [TAG_W-1:0] tag_q, tag_d;
  logic             stb_q;

  always_comb begin
    vld_d  = vld_q;
    kind_d = kind_q;
    tag_d  = tag_q;
    if (load) begin
      vld_d  = 1'b1;
      kind_d = load_wr ? TK_WRITE : TK_READ;
      tag_d  = load_tag;
    end else if (done) begin
      vld_d  = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      kind_q <= TK_READ;
      tag_q  <= '0;
      stb_q  <= 1'b0;
    end else begin
      vld_q <= vld_d;
      stb_q <= load;
      if (load) begin
        kind_q <= kind_d;
        tag_q  <= tag_d;
      end
    end
  end

  assign act_valid = vld_q;
  assign act_write = (kind_q == TK_WRITE);
  assign act_tag   = tag_q;
  assign take_mstr = stb_q;

  AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    take_mstr |=> !take_mstr); // R6
  AST_STROBE_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    take_mstr |-> act_valid); // R6
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (done && act_valid) |=> !act_valid); // R9
endmodule

// File: rtl/dts_sched.sv
// Top: data-tenure scheduler with write bypass on grant.
module dts_sched #(
  parameter int DEPTH = 2,
  parameter int TAG_W = 4,
  parameter int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  parameter int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enq_valid,
  input  logic             enq_write,
  input  logic [TAG_W-1:0] enq_tag,
  input  logic             gnt,
  input  logic             wr_prio,
  input  logic             done,
  output logic             take_mstr,
  output logic             act_valid,
  output logic             act_write,
  output logic [TAG_W-1:0] act_tag,
  output logic [CNT_W-1:0] q_count,
  output logic             ovf_err
);
  logic [DEPTH-1:0]            slot_vld, slot_wr;
  logic [DEPTH-1:0][TAG_W-1:0] slot_tag;
  logic [IDX_W-1:0]            sel_idx;
  logic                        any_wr;
  logic                        accept, room, push, ovf_d, ovf_q;

  assign accept = gnt && (q_count != '0) && !act_valid;
  assign room   = (q_count < CNT_W'(DEPTH)) || accept;
  assign push   = enq_valid && room;
  assign ovf_d  = enq_valid && !room;

  dts_pick #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_pick (
    .slot_vld (slot_vld),
    .slot_wr  (slot_wr),
    .prio     (wr_prio),
    .sel_idx  (sel_idx),
    .any_wr   (any_wr)
  );

  dts_queue #(.DEPTH(DEPTH), .TAG_W(TAG_W), .IDX_W(IDX_W), .CNT_W(CNT_W)) u_queue (
    .clk      (clk),
    .rst_n    (rst_n),
    .pop      (accept),
    .pop_idx  (sel_idx),
    .push     (push),
    .push_wr  (enq_write),
    .push_tag (enq_tag),
    .slot_vld (slot_vld),
    .slot_wr  (slot_wr),
    .slot_tag (slot_tag),
    .count    (q_count)
  );

  dts_active #(.TAG_W(TAG_W)) u_active (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .load_wr   (slot_wr[sel_idx]),
    .load_tag  (slot_tag[sel_idx]),
    .done      (done),
    .act_valid (act_valid),
    .act_write (act_write),
    .act_tag   (act_tag),
    .take_mstr (take_mstr)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ovf_q <= 1'b0;
    else        ovf_q <= ovf_d;
  end
  assign ovf_err = ovf_q;

  AST_NO_GRANT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (gnt && (q_count == '0)) |=> !take_mstr); // R5
  AST_OVF_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_err |-> (q_count == CNT_W'(DEPTH))); // R8
  AST_PRIO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && wr_prio && any_wr) |=> act_write); // R3
  AST_ORDER_DEFAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (accept && !wr_prio) |=> (act_tag == $past(slot_tag[0]))); // R2
endmodule

// File: tb/test_dts_sched.sv
module test_dts_sched;
  localparam int DEPTH = 2;
  localparam int TAG_W = 4;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enq_valid = 1'b0, enq_write = 1'b0, gnt = 1'b0, wr_prio = 1'b0, done = 1'b0;
  logic [TAG_W-1:0] enq_tag = '0;
  logic take_mstr, act_valid, act_write, ovf_err;
  logic [TAG_W-1:0] act_tag;
  logic [CNT_W-1:0] q_count;

  always #5 clk = ~clk;

  dts_sched #(.DEPTH(DEPTH), .TAG_W(TAG_W)) i_dts_sched (
    .clk(clk), .rst_n(rst_n), .enq_valid(enq_valid), .enq_write(enq_write),
    .enq_tag(enq_tag), .gnt(gnt), .wr_prio(wr_prio), .done(done),
    .take_mstr(take_mstr), .act_valid(act_valid), .act_write(act_write),
    .act_tag(act_tag), .q_count(q_count), .ovf_err(ovf_err)
  );

  int n_chk = 0, n_bad = 0;
  // behavioural model
  int         m_cnt;
  logic       m_k[DEPTH];
  logic [TAG_W-1:0] m_t[DEPTH];
  logic       m_av, m_aw, m_take, m_ovf;
  logic [TAG_W-1:0] m_at;
  logic [TAG_W-1:0] tag_ctr = 4'h1;

  task automatic chk(input string req, input string what, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic compare(input string req);
    chk(req, "take_mstr", int'(take_mstr), int'(m_take));
    chk(req, "act_valid", int'(act_valid), int'(m_av));
    if (m_av) begin
      chk(req, "act_write", int'(act_write), int'(m_aw));
      chk(req, "act_tag", int'(act_tag), int'(m_at));
    end
    chk(req, "q_count", int'(q_count), m_cnt);
    chk(req, "ovf_err", int'(ovf_err), int'(m_ovf));
  endtask

  task automatic model_reset();
    m_cnt = 0; m_av = 0; m_aw = 0; m_at = '0; m_take = 0; m_ovf = 0;
    for (int i = 0; i < DEPTH; i++) begin m_k[i] = 0; m_t[i] = '0; end
  endtask

  task automatic model_step(input logic e, input logic ew, input logic [TAG_W-1:0] et,
                            input logic g, input logic p, input logic d);
    logic acc;
    int sel;
    acc = g && (m_cnt > 0) && !m_av;
    sel = 0;
    if (p) begin
      for (int i = m_cnt - 1; i >= 0; i--) if (m_k[i]) sel = i;
    end
    m_take = acc;
    if (acc) begin
      m_av = 1; m_aw = m_k[sel]; m_at = m_t[sel];
      for (int i = sel; i < m_cnt - 1; i++) begin m_k[i] = m_k[i+1]; m_t[i] = m_t[i+1]; end
      m_cnt--;
    end else if (d) begin
      m_av = 0;
    end
    m_ovf = 0;
    if (e) begin
      if (m_cnt < DEPTH) begin m_k[m_cnt] = ew; m_t[m_cnt] = et; m_cnt++; end
      else m_ovf = 1;
    end
  endtask

  task automatic cyc(input string req, input logic e, input logic ew,
                     input logic g, input logic p, input logic d);
    logic [TAG_W-1:0] t;
    t = tag_ctr;
    if (e) tag_ctr = tag_ctr + 4'h1;
    enq_valid = e; enq_write = ew; enq_tag = t; gnt = g; wr_prio = p; done = d;
    @(posedge clk);
    model_step(e, ew, t, g, p, d);
    @(negedge clk);
    enq_valid = 0; gnt = 0; wr_prio = 0; done = 0;
    compare(req);
  endtask

  task automatic drain();
    for (int k = 0; k < 6; k++) begin
      cyc("R9", 0, 0, 0, 0, 1);
      cyc("R2", 0, 0, 1, 0, 0);
    end
    cyc("R9", 0, 0, 0, 0, 1);
  endtask

  int cycles = 0;
  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 200000) begin
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
      end
    end
  end

  initial begin
    model_reset();
    repeat (2) @(negedge clk);
    compare("R1");
    rst_n = 1'b1;
    @(negedge clk);
    compare("R1");

    // R5: grant on empty queue
    cyc("R5", 0, 0, 1, 1, 0);

    // exhaustive fillings x prio
    for (int len = 0; len <= DEPTH; len++) begin
      for (int pat = 0; pat < (1 << len); pat++) begin
        for (int p = 0; p < 2; p++) begin
          string tg;
          logic aw;
          aw = 0;
          for (int i = 0; i < len; i++) begin
            cyc("R8", 1, pat[i], 0, 0, 0);
            aw |= pat[i];
          end
          if (len == 0) tg = "R5";
          else if (p == 1 && aw) tg = "R3";
          else if (p == 1) tg = "R4";
          else tg = "R2";
          cyc(tg, 0, 0, 1, p[0], 0);
          cyc("R6", 1, 0, 0, 0, 0);        // strobe drops, newer entry queued
          cyc("R5", 0, 0, 1, 0, 0);        // grant while active ignored
          cyc("R9", 0, 0, 0, 0, 1);
          cyc("R7", 0, 0, 1, 0, 0);        // passed entry still ahead
          drain();
        end
      end
    end

    // R8: overflow without grant
    cyc("R8", 1, 0, 0, 0, 0);
    cyc("R8", 1, 1, 0, 0, 0);
    cyc("R8", 1, 1, 0, 0, 0);
    // R10: full queue, grant and enqueue together
    cyc("R10", 1, 1, 1, 1, 0);
    // R11: prio without grant
    cyc("R11", 0, 0, 0, 1, 0);
    // R9: done with enqueue same cycle
    cyc("R9", 0, 0, 0, 0, 1);
    cyc("R9", 0, 0, 0, 0, 1);        // done with nothing active
    cyc("R2", 0, 0, 1, 0, 0);
    cyc("R9", 1, 0, 0, 0, 1);
    cyc("R7", 0, 0, 1, 0, 0);
    drain();

    // pseudo-random run
    for (int n = 0; n < 4000; n++) begin
      logic [5:0] r;
      r = 6'($urandom);
      cyc("R6", r[0] & r[1], r[2], r[3], r[4], r[5] & r[0]);
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule